// File: doc/BRIEF.md
# Strided Memory Access Generator

This block expands a single stream command into a sequence of word read requests for a memory system. A command names a start byte address, a stride in bytes, a run length in words and a number of runs. The generator walks a two-dimensional pattern. It issues a contiguous run of words, moves the run start forward by the stride, and repeats until every run has been issued.

Alongside each memory address it produces a local scratchpad write index. The index starts at the offset given in the command and counts up by one word per request. It keeps counting across run boundaries, so the strided data lands packed in local storage. Commands arrive over a valid/ready handshake. Requests leave over a second valid/ready handshake. A one-cycle done pulse marks the end of each command. Data movement itself is handled elsewhere.

Top module: `strided_access_gen`

## Requirements
- R1: After reset, `req_valid` and `done` are 0 and `cmd_ready` is 1.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the cycle after a non-empty command is taken until the edge of its final request transfer. While it is 0, commands are ignored.
- R3: The cycle after a non-empty command is taken, `req_valid` is 1. The first request carries `req_addr` = start address and `req_spad` = scratchpad offset.
- R4: Inside a run, each request address is the previous one plus 4 bytes (one word), modulo 2^32.
- R5: Run k (counting from 0) begins at start address + k × stride, modulo 2^32.
- R6: A command issues exactly run length × run count requests. `req_last` is 1 only on the final one.
- R7: `req_spad` increases by one on every transferred request, including across runs, modulo 2^12.
- R8: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_addr`, `req_spad` and `req_last` hold their values.
- R9: `done` is 1 for exactly the cycle after the final request transfer, and `req_valid` is 0 in that cycle.
- R10: A command with run length 0 or run count 0 issues no requests. It raises `done` in the cycle after it is taken, and `cmd_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Generator idle, command can be taken |
| cmd_base | input | 32 | Start byte address |
| cmd_stride | input | 32 | Byte distance between run starts |
| cmd_words | input | 16 | Words per run |
| cmd_runs | input | 16 | Number of runs |
| cmd_spad | input | 12 | First scratchpad word index |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Memory side accepts request |
| req_addr | output | 32 | Request byte address |
| req_spad | output | 12 | Scratchpad word index for this request |
| req_last | output | 1 | Final request of the command |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any command is offered. They also assume the memory side may drop `req_ready` at any time, but never withdraws a request by other means. The stimulus drives random stalls on `req_ready` and offers junk commands while a command is in flight. It covers zero-length and zero-count commands, address and scratchpad wrap-around, and back-to-back commands taken in the done cycle. All of these stay within a properly reset, handshake-respecting environment.

// File: rtl/sag_pkg.sv
package sag_pkg;
    typedef enum logic {
        SAG_IDLE = 1'b0,
        SAG_RUN  = 1'b1
    } sag_state_e;
endpackage

// File: rtl/sag_counter.sv
module sag_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] start_val,
    input  logic         reload,
    input  logic         dec,
    output logic         is_last
);
    typedef struct packed {
        logic [W-1:0] len;
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.len = start_val;
            st_d.cnt = start_val;
        end else if (reload) begin
            st_d.cnt = st_q.len;
        end else if (dec) begin
            st_d.cnt = st_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign is_last = (st_q.cnt == W'(1));

    // R6: a step never runs past the final position of the pattern
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !start && !reload) |-> (st_q.cnt > W'(1)));
endmodule

// File: rtl/sag_addr_track.sv
module sag_addr_track #(
    parameter int ADDR_W     = 32,
    parameter int SPAD_AW    = 12,
    parameter int WORD_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [ADDR_W-1:0]  start_stride,
    input  logic [SPAD_AW-1:0] start_spad,
    input  logic               step_word,
    input  logic               step_run,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic [SPAD_AW-1:0] cur_spad
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0]  run_base;
        logic [ADDR_W-1:0]  cur;
        logic [ADDR_W-1:0]  stride;
        logic [SPAD_AW-1:0] spad;
    } trk_st_t;

    trk_st_t st_d, st_q;
    logic [ADDR_W-1:0] next_base;

    always_comb begin
        st_d      = st_q;
        next_base = st_q.run_base + st_q.stride;
        if (start) begin
            st_d.run_base = start_addr;
            st_d.cur      = start_addr;
            st_d.stride   = start_stride;
            st_d.spad     = start_spad;
        end else begin
            if (step_run) begin
                st_d.run_base = next_base;
                st_d.cur      = next_base;
            end else if (step_word) begin
                st_d.cur = st_q.cur + STEP;
            end
            if (step_run || step_word) st_d.spad = st_q.spad + SPAD_AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_addr = st_q.cur;
    assign cur_spad = st_q.spad;

    // R4: a step inside a run advances the address by one word
    assert_word_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_word && !step_run && !start) |=> (cur_addr == $past(cur_addr) + STEP));

    // R7: each transferred request moves the scratchpad index by one
    assert_spad_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((step_word || step_run) && !start) |=> (cur_spad == $past(cur_spad) + SPAD_AW'(1)));
endmodule

// File: rtl/strided_access_gen.sv
module strided_access_gen #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int CNT_W      = 16,
    parameter int SPAD_AW    = 12,
    parameter int WORD_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [ADDR_W-1:0]  cmd_base,
    input  logic [ADDR_W-1:0]  cmd_stride,
    input  logic [LEN_W-1:0]   cmd_words,
    input  logic [CNT_W-1:0]   cmd_runs,
    input  logic [SPAD_AW-1:0] cmd_spad,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [SPAD_AW-1:0] req_spad,
    output logic               req_last,
    output logic               done
);
    import sag_pkg::*;

    typedef struct packed {
        sag_state_e state;
        logic       done;
    } top_st_t;

    top_st_t st_d, st_q;

    logic accept, empty_cmd, start, xfer;
    logic word_last, run_last, fin;
    logic word_reload, word_dec, run_dec;

    always_comb begin
        empty_cmd   = (cmd_words == '0) || (cmd_runs == '0);
        accept      = cmd_valid && (st_q.state == SAG_IDLE);
        start       = accept && !empty_cmd;
        xfer        = (st_q.state == SAG_RUN) && req_ready;
        fin         = xfer && word_last && run_last;
        word_dec    = xfer && !word_last;
        word_reload = xfer && word_last && !run_last;
        run_dec     = word_reload;

        st_d      = st_q;
        st_d.done = fin || (accept && empty_cmd);
        if (start)    st_d.state = SAG_RUN;
        else if (fin) st_d.state = SAG_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{state: SAG_IDLE, done: 1'b0};
        else        st_q <= st_d;
    end

    sag_counter #(.W(LEN_W)) u_word_cnt (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_val(cmd_words),
        .reload(word_reload), .dec(word_dec),
        .is_last(word_last)
    );

    sag_counter #(.W(CNT_W)) u_run_cnt (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_val(cmd_runs),
        .reload(1'b0), .dec(run_dec),
        .is_last(run_last)
    );

    sag_addr_track #(.ADDR_W(ADDR_W), .SPAD_AW(SPAD_AW), .WORD_BYTES(WORD_BYTES)) u_track (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_addr(cmd_base), .start_stride(cmd_stride),
        .start_spad(cmd_spad),
        .step_word(word_dec), .step_run(word_reload),
        .cur_addr(req_addr), .cur_spad(req_spad)
    );

    assign cmd_ready = (st_q.state == SAG_IDLE);
    assign req_valid = (st_q.state == SAG_RUN);
    assign req_last  = req_valid && word_last && run_last;
    assign done      = st_q.done;

    // R8: a stalled request is held unchanged
    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                       && $stable(req_spad) && $stable(req_last)));

    // R2: no command is taken while requests are outstanding
    assert_busy_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !cmd_ready);

    // R9: the final transfer is followed by the done pulse
    assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_last) |=> (done && !req_valid));

    // R10: an empty command completes without issuing requests
    assert_empty_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && ((cmd_words == '0) || (cmd_runs == '0)))
            |=> (done && !req_valid && cmd_ready));
endmodule

// File: tb/test_strided_access_gen.sv
module test_strided_access_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_base = '0;
    logic [31:0] cmd_stride = '0;
    logic [15:0] cmd_words = '0;
    logic [15:0] cmd_runs = '0;
    logic [11:0] cmd_spad = '0;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [31:0] req_addr;
    logic [11:0] req_spad;
    logic        req_last;
    logic        done;

    always #4 clk = ~clk;

    strided_access_gen i_strided_access_gen (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_base(cmd_base), .cmd_stride(cmd_stride),
        .cmd_words(cmd_words), .cmd_runs(cmd_runs), .cmd_spad(cmd_spad),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_spad(req_spad), .req_last(req_last),
        .done(done)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit stall_en = 0;
    bit junk_en = 0;

    // reference model state
    logic [31:0] q_addr[$];
    logic [11:0] q_spad[$];
    bit          q_last[$];
    bit          m_done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // model update at the active edge (reads only bench-driven inputs)
    always @(posedge clk) begin
        if (!rst_n) begin
            q_addr.delete(); q_spad.delete(); q_last.delete();
            m_done = 0;
        end else begin
            bit idle_pre;
            idle_pre = (q_addr.size() == 0);
            m_done = 0;
            if (!idle_pre && req_ready) begin
                if (q_last[0]) m_done = 1;
                void'(q_addr.pop_front()); void'(q_spad.pop_front()); void'(q_last.pop_front());
            end
            if (cmd_valid && idle_pre) begin
                if (cmd_words == 0 || cmd_runs == 0) m_done = 1;
                else begin
                    for (int r = 0; r < int'(cmd_runs); r++) begin
                        for (int w = 0; w < int'(cmd_words); w++) begin
                            q_addr.push_back(cmd_base + 32'(r) * cmd_stride + 32'(w * 4));
                            q_spad.push_back(cmd_spad + 12'(r * int'(cmd_words) + w));
                            q_last.push_back((r == int'(cmd_runs) - 1) && (w == int'(cmd_words) - 1));
                        end
                    end
                end
            end
        end
        cycles++;
        if (cycles > 150000) begin
            bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    // per-cycle comparison away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit mv;
            mv = (q_addr.size() != 0);
            chk(cmd_ready == !mv, "R2 cmd_ready", 32'(cmd_ready), 32'(!mv));
            chk(req_valid == mv, "R3/R6 req_valid", 32'(req_valid), 32'(mv));
            chk(done == m_done, "R9/R10 done", 32'(done), 32'(m_done));
            if (mv && req_valid) begin
                chk(req_addr == q_addr[0], "R4/R5/R8 req_addr", req_addr, q_addr[0]);
                chk(req_spad == q_spad[0], "R7/R8 req_spad", 32'(req_spad), 32'(q_spad[0]));
                chk(req_last == q_last[0], "R6 req_last", 32'(req_last), 32'(q_last[0]));
            end
        end
    end

    // ready driver
    always @(negedge clk) begin
        req_ready <= stall_en ? 1'($urandom % 2) : 1'b1;
    end

    task automatic issue(input logic [31:0] b, input logic [31:0] s,
                         input logic [15:0] w, input logic [15:0] r, input logic [11:0] sp);
        @(negedge clk);
        while (q_addr.size() != 0) begin
            cmd_valid  = junk_en;
            cmd_base   = $urandom;
            cmd_stride = $urandom;
            cmd_words  = 16'($urandom % 5);
            cmd_runs   = 16'($urandom % 5);
            cmd_spad   = 12'($urandom);
            @(negedge clk);
        end
        cmd_valid  = 1'b1;
        cmd_base   = b;
        cmd_stride = s;
        cmd_words  = w;
        cmd_runs   = r;
        cmd_spad   = sp;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic drain();
        while (q_addr.size() != 0 || m_done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(req_valid == 1'b0, "R1 req_valid", 32'(req_valid), 0);
        chk(done == 1'b0, "R1 done", 32'(done), 0);
        chk(cmd_ready == 1'b1, "R1 cmd_ready", 32'(cmd_ready), 1);
        rst_n = 1'b1;

        // R3 R4 R5 R7: basic 4x3 pattern, no stalls
        issue(32'h1000, 32'h40, 16'd4, 16'd3, 12'd5);
        drain();
        // R8: same shape under random stalls
        stall_en = 1;
        issue(32'h2000, 32'h100, 16'd3, 16'd4, 12'd0);
        drain();
        // R2: junk offered while busy must be ignored
        junk_en = 1;
        issue(32'h3000, 32'h20, 16'd6, 16'd2, 12'd100);
        issue(32'h4000, 32'h8, 16'd2, 16'd3, 12'd7);
        junk_en = 0;
        drain();
        // R10: empty commands
        issue(32'h5000, 32'h10, 16'd0, 16'd3, 12'd1);
        issue(32'h5000, 32'h10, 16'd3, 16'd0, 12'd1);
        drain();
        // R4 R5 R7: address and scratchpad wrap
        issue(32'hFFFF_FFF0, 32'h10, 16'd5, 16'd2, 12'hFFD);
        drain();
        // R6: single word runs and a single long run
        issue(32'h8000, 32'h200, 16'd1, 16'd5, 12'd9);
        issue(32'h9000, 32'h0, 16'd12, 16'd1, 12'd20);
        // back-to-back, taken in done cycle
        stall_en = 0;
        issue(32'hA000, 32'h30, 16'd2, 16'd2, 12'd0);
        issue(32'hB000, 32'h30, 16'd2, 16'd2, 12'd50);
        drain();
        for (int k = 0; k < 20; k++) begin
            stall_en = k[0];
            issue($urandom, $urandom, 16'($urandom % 7), 16'($urandom % 6), 12'($urandom));
        end
        drain();
        summary();
    end
endmodule